// File: doc/BRIEF.md
# Quiescent State Checker

This block watches a one-bit sample event and, each time that event goes from low to high, compares a multi-bit state value against an expected value presented in the same clock cycle. A mismatch on such an edge produces a one-cycle violation pulse on the following cycle and advances a saturating violation tally. A typical use is to confirm that a controller has settled into the correct resting state at the moment a transaction reports completion. The expected value may differ from one check to the next.

An end-of-check strobe, enabled by a parameter, forces the same comparison on any cycle whatever the sample event is doing. It is meant for a final sweep at the close of a test. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready handshake and no back-pressure.

Top module: `quiet_state_chk`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `viol_pulse` and `viol_count` are 0 after that edge, and no check is made.
- R2: A rising transition is a clock edge where `sample_evt` is 1 and was 0 at the previous edge. If `state_val` differs from `expect_val` on that edge, `viol_pulse` is 1 for the cycle that follows.
- R3: On a rising transition where `state_val` equals `expect_val`, `viol_pulse` stays 0 and `viol_count` does not change.
- R4: While `sample_evt` stays high with no new rising transition, a mismatch is not checked.
- R5: The stored previous event value is held at 1 during reset. An event that is high across reset release is therefore not a transition, and no check by event happens on the first edge after release.
- R6: The comparison uses the `expect_val` present on the checking edge, not any earlier value.
- R7: With `END_EN`=1, `end_strobe`=1 on an edge forces the comparison whatever the value of `sample_evt`.
- R8: With `END_EN`=0, `end_strobe` has no effect on `viol_pulse` or `viol_count`.
- R9: `viol_pulse` is high only for the cycle after a failing edge. It returns to 0 after a passing or unchecked edge.
- R10: `viol_count` (`CNT_W` bits, default 16) rises by one per failing edge and holds at all ones once it gets there.
- R11: `state_val` and `expect_val` share the width parameter `W` (default 1). All `W` bits take part in the comparison.
- R12: A rising transition and an end strobe on the same edge count as one check. A mismatch then adds exactly one to `viol_count`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| state_val | input | W | State under check |
| expect_val | input | W | Value the state must equal on a check |
| sample_evt | input | 1 | Event whose low-to-high transition triggers a check |
| end_strobe | input | 1 | Forces a check on this edge (when `END_EN`=1) |
| viol_pulse | output | 1 | Registered one-cycle violation flag |
| viol_count | output | CNT_W | Saturating count of violations |

## Verification
The event-edge trigger and the end strobe can land on the same edge. The bench provokes this by raising `sample_evt` while `end_strobe` is high and the state mismatches. It judges the result by requiring a single pulse and an increment of exactly one. A second instance with the strobe disabled and a 4-bit counter receives the same stimulus. It shows that the strobe is ignored and that the counter stops at 15 under a run of failing edges.

// File: rtl/quiet_state_pkg.sv
package quiet_state_pkg;

  // Saturating increment for an arbitrary-width tally
  function automatic logic [63:0] sat_step(input logic [63:0] cur,
                                           input logic [63:0] top);
    if (cur >= top) return top;
    return cur + 64'd1;
  endfunction

  typedef enum logic [1:0] {
    TRIG_NONE  = 2'b00,
    TRIG_EDGE  = 2'b01,
    TRIG_FORCE = 2'b10,
    TRIG_BOTH  = 2'b11
  } trig_kind_t;

endpackage

// File: rtl/qs_edge_track.sv
module qs_edge_track (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_evt,
  output logic rise
);

  logic prev_q;

  // History held at 1 during reset so a level across release is not an edge
  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= sample_evt;
  end

  assign rise = sample_evt & ~prev_q;

  // R2
  rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> !$past(sample_evt));

  // R5
  no_rise_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> !rise);

endmodule

// File: rtl/qs_compare.sv
module qs_compare
  import quiet_state_pkg::*;
#(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rise,
  input  logic         force_chk,
  input  logic [W-1:0] state_val,
  input  logic [W-1:0] expect_val,
  output logic         fail_now,
  output logic         viol_pulse
);

  trig_kind_t kind;
  logic       armed;
  logic       differs;

  assign kind    = trig_kind_t'({force_chk, rise});
  assign armed   = (kind != TRIG_NONE);
  assign differs = (state_val != expect_val);
  assign fail_now = armed & differs;

  always_ff @(posedge clk) begin
    if (!rst_n) viol_pulse <= 1'b0;
    else        viol_pulse <= fail_now;
  end

  // R9
  pulse_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse |-> $past(armed) && $past(state_val != expect_val));

  // R3
  match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && state_val == expect_val) |=> !viol_pulse);

  // R4
  no_trigger_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && !force_chk) |=> !viol_pulse);

endmodule

// File: rtl/qs_sat_counter.sv
module qs_sat_counter
  import quiet_state_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [63:0] stepped;

  assign stepped = sat_step(64'(count), 64'(CNT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (bump) count <= stepped[CNT_W-1:0];
  end

  // R10
  step_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && (count != $past(count)) |-> (count == $past(count) + 1'b1));

  // R10
  hold_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX) |=> (count == CNT_MAX));

endmodule

// File: rtl/quiet_state_chk.sv
module quiet_state_chk #(
  parameter int W      = 1,
  parameter int CNT_W  = 16,
  parameter bit END_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     state_val,
  input  logic [W-1:0]     expect_val,
  input  logic             sample_evt,
  input  logic             end_strobe,
  output logic             viol_pulse,
  output logic [CNT_W-1:0] viol_count
);

  logic rise;
  logic force_chk;
  logic fail_now;

  qs_edge_track u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_evt (sample_evt),
    .rise       (rise)
  );

  generate
    if (END_EN) begin : g_end_on
      assign force_chk = end_strobe;
    end else begin : g_end_off
      assign force_chk = 1'b0;
      // R8
      strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_now |-> rise);
    end
  endgenerate

  qs_compare #(.W(W)) u_cmp (
    .clk        (clk),
    .rst_n      (rst_n),
    .rise       (rise),
    .force_chk  (force_chk),
    .state_val  (state_val),
    .expect_val (expect_val),
    .fail_now   (fail_now),
    .viol_pulse (viol_pulse)
  );

  qs_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .bump  (fail_now),
    .count (viol_count)
  );

  // R12
  one_per_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (viol_count - $past(viol_count)) <= 1);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !$past(rst_n) |-> (!viol_pulse && viol_count == '0));

endmodule

// File: tb/quiet_state_chk_bench.sv
module quiet_state_chk_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] state_val = '0;
  logic [W-1:0] expect_val = '0;
  logic sample_evt = 1'b0;
  logic end_strobe = 1'b0;
  logic viol_pulse, ne_pulse;
  logic [15:0] viol_count;
  logic [3:0] ne_count;

  int checks = 0;
  int errors = 0;
  int exp_main = 0;
  int exp_ne = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  quiet_state_chk #(.W(W), .CNT_W(16), .END_EN(1'b1)) u_quiet_state_chk (
    .clk(clk), .rst_n(rst_n), .state_val(state_val), .expect_val(expect_val),
    .sample_evt(sample_evt), .end_strobe(end_strobe),
    .viol_pulse(viol_pulse), .viol_count(viol_count));

  quiet_state_chk #(.W(W), .CNT_W(4), .END_EN(1'b0)) u_quiet_state_chk_noend (
    .clk(clk), .rst_n(rst_n), .state_val(state_val), .expect_val(expect_val),
    .sample_evt(sample_evt), .end_strobe(end_strobe),
    .viol_pulse(ne_pulse), .viol_count(ne_count));

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Drive at negedge, let one rising edge pass, return at the next negedge
  task automatic step(input logic sev, input logic [W-1:0] st,
                      input logic [W-1:0] ex, input logic es);
    sample_evt = sev; state_val = st; expect_val = ex; end_strobe = es;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    sample_evt = 1'b1; state_val = 4'd1; expect_val = 4'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 pulse in reset", viol_pulse, 0);
    chk("R1 count in reset", viol_count, 0);
    exp_main = 0; exp_ne = 0;
    rst_n = 1'b1;
  endtask

  task automatic t_held_across_reset();
    step(1'b1, 4'd1, 4'd2, 1'b0);
    chk("R5 no check on first edge", viol_pulse, 0);
    step(1'b1, 4'd3, 4'd9, 1'b0);
    chk("R4 level high no check", viol_pulse, 0);
    chk("R4 count unchanged", viol_count, exp_main);
  endtask

  task automatic t_rise_mismatch();
    step(1'b0, 4'd0, 4'd0, 1'b0);
    step(1'b1, 4'd8, 4'd0, 1'b0);
    exp_main++; exp_ne++;
    chk("R2 pulse on mismatch rise", viol_pulse, 1);
    chk("R11 msb-only difference counted", viol_count, exp_main);
    step(1'b1, 4'd8, 4'd0, 1'b0);
    chk("R9 pulse back to 0", viol_pulse, 0);
  endtask

  task automatic t_rise_match();
    step(1'b0, 4'd0, 4'd7, 1'b0);
    step(1'b1, 4'd6, 4'd6, 1'b0);
    chk("R3 match no pulse", viol_pulse, 0);
    chk("R3 count unchanged", viol_count, exp_main);
  endtask

  task automatic t_current_expect();
    step(1'b0, 4'd5, 4'd3, 1'b0);
    step(1'b1, 4'd5, 4'd5, 1'b0);
    chk("R6 current expect matches", viol_pulse, 0);
    step(1'b0, 4'd5, 4'd5, 1'b0);
    step(1'b1, 4'd5, 4'd6, 1'b0);
    exp_main++; exp_ne++;
    chk("R6 current expect differs", viol_pulse, 1);
  endtask

  task automatic t_end_strobe();
    step(1'b0, 4'd2, 4'd4, 1'b1);
    exp_main++;
    chk("R7 strobe forces check", viol_pulse, 1);
    chk("R8 strobe ignored pulse", ne_pulse, 0);
    chk("R8 strobe ignored count", ne_count, exp_ne);
    step(1'b0, 4'd4, 4'd4, 1'b1);
    chk("R7 strobe with match", viol_pulse, 0);
  endtask

  task automatic t_both();
    step(1'b0, 4'd0, 4'd0, 1'b0);
    step(1'b1, 4'd1, 4'd2, 1'b1);
    exp_main++; exp_ne++;
    chk("R12 coincident pulse", viol_pulse, 1);
    chk("R12 single increment", viol_count, exp_main);
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 20; i++) begin
      step(1'b0, 4'd0, 4'd0, 1'b0);
      step(1'b1, 4'd3, 4'd1, 1'b0);
      exp_main++;
      if (exp_ne < 15) exp_ne++;
    end
    chk("R10 small counter saturates", ne_count, exp_ne);
    chk("R10 wide counter tally", viol_count, exp_main);
    step(1'b0, 4'd0, 4'd0, 1'b0);
    step(1'b1, 4'd3, 4'd1, 1'b0);
    chk("R10 holds at max", ne_count, 15);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_held_across_reset();
    t_rise_mismatch();
    t_rise_match();
    t_current_expect();
    t_end_strobe();
    t_both();
    t_saturate();
    t_reset();
    t_held_across_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule